// File: doc/BRIEF.md
# Quadrature Preset Counter with Compare Outputs

This block counts a two-phase quadrature signal into a decimal-range present value (0 to 999999) and compares that value against a programmable setpoint. Both phases and a count-clear input are first brought into the system clock domain through synchronizer chains. The second phase carries the counting edge, and the level of the first phase at that moment gates it. A falling edge of phase B while phase A is low counts up, and a rising edge of phase B while phase A is low counts down. Phase B edges that arrive while phase A is high are part of the cycle but do not count.

When a count step lands the present value on the setpoint, two identical outputs switch on. They either stay on until the next accepted clear or stay on for a programmed number of clock cycles. A mode input chooses between two behaviours once the setpoint is reached. In the free-running mode the count keeps following the input. In the hold mode the count freezes at the setpoint until it is cleared.

The clear input acts only after it has been held for a programmed minimum number of cycles. It then zeroes the count, drops the outputs and blocks counting until it is released.

Top module: `quad_preset_counter`

## Requirements
- R1: A synchronized falling edge of `cnt_b` while synchronized `cnt_a` is 0 adds 1 to `pv`. The new value appears on the third rising clock edge after the input change.
- R2: A synchronized rising edge of `cnt_b` while `cnt_a` is 0 subtracts 1 from `pv`. Edges of `cnt_b` while `cnt_a` is 1, and all edges of `cnt_a`, leave `pv` unchanged.
- R3: `pv` stays within 0..999999. An up step from 999999 gives 0, and a down step from 0 gives 999999.
- R4: `out1` and `out2` are equal in every cycle.
- R5: A count step that moves `pv` from a value different from `setpoint` onto `setpoint` turns both outputs on in the same cycle in which `pv` changes.
- R6: With `out_latched`=0, the outputs stay on for `pulse_cycles` clock cycles after turn-on and then turn off. A value of 0 acts as 1.
- R7: With `out_latched`=1, the outputs stay on until a clear is accepted.
- R8: With `hold_mode`=0, counting continues past the setpoint in both directions.
- R9: With `hold_mode`=1, once the setpoint has been reached, further count steps are ignored until a clear is accepted.
- R10: A clear is accepted when synchronized `clr_in` has been 1 for `clr_min_cycles` consecutive cycles (0 acts as 1). On acceptance `pv` becomes 0 and both outputs turn off, one clock edge later.
- R11: A `clr_in` pulse shorter than `clr_min_cycles` cycles has no effect on `pv` or on the outputs.
- R12: While an accepted clear is still held, count steps are ignored. After `clr_in` returns to 0, counting resumes.
- R13: After `rst_n` is asserted, `pv` is 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cnt_a | input | 1 | Quadrature phase A (gating phase), asynchronous |
| cnt_b | input | 1 | Quadrature phase B (counting phase), asynchronous |
| clr_in | input | 1 | Count clear request, asynchronous, active high |
| setpoint | input | 20 | Compare value, 0..999999 |
| hold_mode | input | 1 | 1: freeze at setpoint; 0: keep counting |
| out_latched | input | 1 | 1: outputs held on; 0: timed pulse |
| pulse_cycles | input | 16 | Output pulse width in clock cycles |
| clr_min_cycles | input | 16 | Minimum accepted clear width in clock cycles |
| pv | output | 20 | Present count value |
| out1 | output | 1 | Compare output 1 |
| out2 | output | 1 | Compare output 2 |

## Verification
A phase change reaches `pv` and the outputs on the third rising edge after the input change: two synchronizer stages plus the count register. The driver therefore waits three edges after each phase move and queues its expectation 1 ns after that edge, and the monitor compares at the next falling edge. A clear held for N cycles takes effect on edge N+2 after it is driven, and the bench samples several edges later. Pulse widths are measured from the turn-on edge: the output is checked still on after `pulse_cycles`-1 further edges and off after one more.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } qpc_step_e;

  // Next value for an up step in a 0..maxv ring
  function automatic int unsigned wrap_up(int unsigned cur, int unsigned maxv);
    return (cur >= maxv) ? 0 : cur + 1;
  endfunction

  // Next value for a down step in a 0..maxv ring
  function automatic int unsigned wrap_down(int unsigned cur, int unsigned maxv);
    return (cur == 0) ? maxv : cur - 1;
  endfunction

  // True when a clear held for held+1 cycles meets the minimum width
  function automatic logic clr_due(int unsigned held, int unsigned min_w);
    int unsigned need;
    need = (min_w == 0) ? 1 : min_w;
    return (held + 1) >= need;
  endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qpc_quad_dec.sv
module qpc_quad_dec
  import qpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      a_s,
  input  logic      b_s,
  output qpc_step_e step
);
  logic b_d;
  logic b_rise, b_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) b_d <= 1'b0;
    else        b_d <= b_s;

  assign b_rise = b_s & ~b_d;
  assign b_fall = ~b_s & b_d;

  always_comb begin
    step = STEP_NONE;
    if (!a_s) begin
      if (b_fall)      step = STEP_UP;
      else if (b_rise) step = STEP_DOWN;
    end
  end
endmodule

// File: rtl/qpc_clr_filter.sv
module qpc_clr_filter
  import qpc_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_s,
  input  logic [TW-1:0] min_cycles,
  output logic          fire,
  output logic          active
);
  logic [TW-1:0] held;

  assign fire = clr_s && !active && clr_due(32'(held), 32'(min_cycles));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               held <= '0;
    else if (!clr_s)          held <= '0;
    else if (held != '1)      held <= held + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      active <= 1'b0;
    else if (!clr_s) active <= 1'b0;
    else if (fire)   active <= 1'b1;
endmodule

// File: rtl/qpc_out_timer.sv
module qpc_out_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          clr_fire,
  input  logic          latched,
  input  logic [TW-1:0] pulse_cycles,
  output logic          out_on
);
  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_on <= 1'b0;
      remain <= '0;
    end else if (clr_fire) begin
      out_on <= 1'b0;
      remain <= '0;
    end else if (hit) begin
      out_on <= 1'b1;
      remain <= pulse_cycles;
    end else if (out_on && !latched) begin
      if (remain <= 1) out_on <= 1'b0;
      else             remain <= remain - 1'b1;
    end
endmodule

// File: rtl/quad_preset_counter.sv
module quad_preset_counter
  import qpc_pkg::*;
#(
  parameter int PV_MAX      = 999999,
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  localparam int PV_W       = $clog2(PV_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_a,
  input  logic            cnt_b,
  input  logic            clr_in,
  input  logic [PV_W-1:0] setpoint,
  input  logic            hold_mode,
  input  logic            out_latched,
  input  logic [TW-1:0]   pulse_cycles,
  input  logic [TW-1:0]   clr_min_cycles,
  output logic [PV_W-1:0] pv,
  output logic            out1,
  output logic            out2
);
  logic [2:0]      raw_in, synced;
  logic            a_s, b_s, clr_s;
  qpc_step_e       step;
  logic            clr_fire, clr_active;
  logic            reached, frozen, count_en;
  logic            step_up, step_down, hit, out_on;
  logic [PV_W-1:0] pv_next;

  assign raw_in = {clr_in, cnt_b, cnt_a};

  qpc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(synced)
  );

  assign a_s   = synced[0];
  assign b_s   = synced[1];
  assign clr_s = synced[2];

  qpc_quad_dec u_dec (
    .clk(clk), .rst_n(rst_n), .a_s(a_s), .b_s(b_s), .step(step)
  );

  qpc_clr_filter #(.TW(TW)) u_clr (
    .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .min_cycles(clr_min_cycles),
    .fire(clr_fire), .active(clr_active)
  );

  // Event wires used by the bound checker
  assign frozen    = hold_mode && reached;
  assign count_en  = !clr_active && !clr_fire && !frozen;
  assign step_up   = count_en && (step == STEP_UP);
  assign step_down = count_en && (step == STEP_DOWN);

  always_comb begin
    pv_next = pv;
    if (step_up)        pv_next = PV_W'(wrap_up(32'(pv), PV_MAX));
    else if (step_down) pv_next = PV_W'(wrap_down(32'(pv), PV_MAX));
  end

  assign hit = (step_up || step_down) && (pv_next == setpoint) && (pv != setpoint);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pv      <= '0;
      reached <= 1'b0;
    end else if (clr_fire) begin
      pv      <= '0;
      reached <= 1'b0;
    end else begin
      pv <= pv_next;
      if (hit) reached <= 1'b1;
    end

  qpc_out_timer #(.TW(TW)) u_out (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr_fire(clr_fire),
    .latched(out_latched), .pulse_cycles(pulse_cycles), .out_on(out_on)
  );

  assign out1 = out_on;
  assign out2 = out_on;
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int PV_MAX = 999999,
  parameter int PV_W   = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PV_W-1:0] pv,
  input logic            out1,
  input logic            out2,
  input logic            out_latched,
  input logic            step_up,
  input logic            step_down,
  input logic            hit,
  input logic            clr_fire,
  input logic            clr_active,
  input logic            frozen
);
  assert_outs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out1 == out2);

  assert_pv_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pv <= PV_W'(PV_MAX));

  assert_wrap_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && pv == PV_W'(PV_MAX)) |=> pv == '0);

  assert_wrap_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_down && pv == '0) |=> pv == PV_W'(PV_MAX));

  assert_hit_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> out1);

  assert_latched_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out1 && out_latched && !clr_fire) |=> out1);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !clr_fire) |=> $stable(pv));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (pv == '0 && !out1));

  assert_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |=> $stable(pv));
endmodule

bind quad_preset_counter qpc_checker #(.PV_MAX(PV_MAX), .PV_W(PV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pv(pv), .out1(out1), .out2(out2),
  .out_latched(out_latched), .step_up(step_up), .step_down(step_down),
  .hit(hit), .clr_fire(clr_fire), .clr_active(clr_active), .frozen(frozen)
);

// File: tb/tb_quad_preset_counter.sv
`timescale 1ns/1ps
module tb_quad_preset_counter;
  localparam int RING = 1000000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cnt_a = 0, cnt_b = 0, clr_in = 0;
  logic [19:0] setpoint = 20'd3;
  logic        hold_mode = 0, out_latched = 0;
  logic [15:0] pulse_cycles = 16'd5, clr_min_cycles = 16'd3;
  logic [19:0] pv;
  logic        out1, out2;

  always #2 clk = ~clk;

  quad_preset_counter dut (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b), .clr_in(clr_in),
    .setpoint(setpoint), .hold_mode(hold_mode), .out_latched(out_latched),
    .pulse_cycles(pulse_cycles), .clr_min_cycles(clr_min_cycles),
    .pv(pv), .out1(out1), .out2(out2)
  );

  typedef struct {
    int    pv_e;
    bit    out_e;
    string req;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   checks = 0, fails = 0;
  int   model_pv = 0;
  bit   done = 0;

  // Monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      if (int'(pv) != cur.pv_e) begin
        fails++;
        $display("FAIL %s: pv actual %0d expected %0d", cur.req, pv, cur.pv_e);
      end
      checks++;
      if (out1 !== cur.out_e) begin
        fails++;
        $display("FAIL %s: out1 actual %0b expected %0b", cur.req, out1, cur.out_e);
      end
      checks++;
      if (out2 !== out1) begin
        fails++;
        $display("FAIL R4: out2 actual %0b expected %0b", out2, out1);
      end
    end
  end

  task automatic expect_now(input int pv_e, input bit out_e, input string req);
    #1;
    q.push_back('{pv_e, out_e, req});
  endtask

  task automatic move(input bit on_b, input bit val);
    @(negedge clk);
    if (on_b) cnt_b = val; else cnt_a = val;
    repeat (3) @(posedge clk);
  endtask

  // Up cycle: the count lands on its final move
  task automatic quad_up();
    move(0, 1); move(1, 1); move(0, 0); move(1, 0);
    model_pv = (model_pv + 1) % RING;
  endtask

  // Down cycle: the count lands on its first move
  task automatic down_first();
    move(1, 1);
    model_pv = (model_pv + RING - 1) % RING;
  endtask

  task automatic down_rest();
    move(0, 1); move(1, 0); move(0, 0);
  endtask

  task automatic clr_pulse(input int n);
    @(negedge clk);
    clr_in = 1;
    repeat (n) @(negedge clk);
    clr_in = 0;
    repeat (4) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (2) @(posedge clk);
    expect_now(0, 0, "R13");

    // R1 up counting, R5 compare hit, R6 pulse width
    quad_up(); expect_now(model_pv, 0, "R1");
    quad_up(); expect_now(model_pv, 0, "R1");
    quad_up(); expect_now(model_pv, 1, "R5");
    repeat (4) @(posedge clk); expect_now(model_pv, 1, "R6");
    @(posedge clk);            expect_now(model_pv, 0, "R6");

    // R8 counting continues past the setpoint
    quad_up(); expect_now(model_pv, 0, "R8");

    // R2 down counting, re-entering setpoint fires again (R5)
    down_first(); expect_now(model_pv, 1, "R5");
    down_rest();  expect_now(model_pv, 0, "R2");
    for (int i = 0; i < 3; i++) begin
      down_first(); down_rest(); expect_now(model_pv, 0, "R2");
    end

    // R3 wrap in both directions
    down_first(); down_rest(); expect_now(model_pv, 0, "R3");
    quad_up();                 expect_now(model_pv, 0, "R3");

    // R11 short clear ignored, R10 full-width clear accepted
    quad_up(); expect_now(model_pv, 0, "R1");
    clr_pulse(2); expect_now(model_pv, 0, "R11");
    clr_pulse(3); model_pv = 0; expect_now(0, 0, "R10");

    // R12 counting blocked while an accepted clear is held
    @(negedge clk);
    out_latched = 1; hold_mode = 1; setpoint = 20'd2;
    clr_in = 1;
    repeat (6) @(posedge clk);
    quad_up(); model_pv = 0; expect_now(0, 0, "R12");
    @(negedge clk) clr_in = 0;
    repeat (4) @(posedge clk);
    quad_up(); expect_now(model_pv, 0, "R12");

    // R7 latched outputs, R9 freeze at setpoint
    quad_up(); expect_now(model_pv, 1, "R7");
    repeat (20) @(posedge clk); expect_now(model_pv, 1, "R7");
    quad_up(); model_pv = 2; expect_now(2, 1, "R9");
    down_first(); down_rest(); model_pv = 2; expect_now(2, 1, "R9");
    clr_pulse(3); model_pv = 0; expect_now(0, 0, "R10");

    // R6 zero pulse width acts as one cycle
    @(negedge clk);
    out_latched = 0; hold_mode = 0; setpoint = 20'd1; pulse_cycles = 16'd0;
    quad_up(); expect_now(model_pv, 1, "R6");
    @(posedge clk); expect_now(model_pv, 0, "R6");

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule